// File: doc/BRIEF.md
# Lifecycle-Gated JTAG Target Selector

This block connects one external JTAG port to at most one of three internal TAP targets: the lifecycle controller TAP, the RISC-V debug module TAP and the DFT TAP. A 2-bit select strap picks the target. An encoded lifecycle-state input decides which targets may be picked and whether the strap is sampled once or followed continuously. The block also carries a 2-bit DFT test-mode strap to an output, but only in the unlocked test states and in RMA.

After reset the block stays in an idle condition with no target selected until the lifecycle state is reported valid. On the first clock edge with that input high, it captures the select strap, the DFT strap and the state's permission class. In test-unlocked and RMA states the selected target then follows the select strap on every clock, so the target can be changed without a reset. In every other state the choice is fixed until the next reset. Only the selected target sees the external TCK, TMS, TDI and TRST_N. The other targets receive all-zero requests. The external TDO comes from the selected target and is gated by that target's output enable.

Top module: `jtag_strap_mux`

## Requirements
- R1: While reset is asserted, and after reset until the first clock edge with `lc_valid_i` high, no target is selected: every `tap_*_o` bit is 0, `jtag_tdo_o` is 0 and `dft_strap_o` is 0.
- R2: On the first rising clock edge with `lc_valid_i` high after reset, the block captures the selection, the DFT strap and the permission class. The result appears on the outputs right after that edge. Later values of `lc_valid_i` and `lc_state_i` have no effect until the next reset.
- R3: The select strap is encoded as 2'b00 = none, 2'b01 = lifecycle TAP (target index 0), 2'b10 = RISC-V TAP (index 1) and 2'b11 = DFT TAP (index 2).
- R4: If the captured state is test-unlocked 0 to 7 (`lc_state_i` codes 2 to 9) or RMA (code 13), every strap value is allowed. The selection follows `tap_strap_i` on every later clock edge and becomes visible after the next rising edge.
- R5: If the captured state is dev (code 10), the lifecycle and RISC-V TAPs may be selected. A strap of 2'b11 selects none.
- R6: If the captured state is prod (code 11), or any other state that is neither live nor dev (raw 0, test-locked 1, prod-end 12, scrap 14 and unlisted codes), only strap bit 0 counts. A 1 selects the lifecycle TAP and a 0 selects none.
- R7: Outside the states of R4, changes on `tap_strap_i` after capture have no effect on the selection.
- R8: `dft_strap_o` holds the DFT strap captured per R2 when the captured state is one of the R4 states. Otherwise it is 2'b00, whatever `dft_strap_i` holds.
- R9: After capture, `dft_strap_o` stays unchanged in every state while `dft_strap_i` changes.
- R10: The selected target's TCK, TMS, TDI and TRST_N outputs equal the external inputs. Every unselected target's four request outputs are 0.
- R11: `jtag_tdo_o` equals the selected target's TDO when that target's output enable is 1, and is 0 otherwise. With no target selected it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lc_state_i | input | 5 | Encoded lifecycle state |
| lc_valid_i | input | 1 | Lifecycle state is valid; qualifies the capture |
| tap_strap_i | input | 2 | Target select strap |
| dft_strap_i | input | 2 | DFT test-mode strap |
| jtag_tck_i | input | 1 | External TCK |
| jtag_tms_i | input | 1 | External TMS |
| jtag_tdi_i | input | 1 | External TDI |
| jtag_trst_n_i | input | 1 | External TRST_N |
| jtag_tdo_o | output | 1 | External TDO |
| tap_tck_o | output | 3 | Per-target TCK (index 0 lifecycle, 1 RISC-V, 2 DFT) |
| tap_tms_o | output | 3 | Per-target TMS |
| tap_tdi_o | output | 3 | Per-target TDI |
| tap_trst_n_o | output | 3 | Per-target TRST_N |
| tap_tdo_i | input | 3 | Per-target TDO |
| tap_tdo_oe_i | input | 3 | Per-target TDO output enable |
| dft_strap_o | output | 2 | Gated DFT strap |

## Verification
The bench runs every lifecycle code, including an unlisted one, against every initial strap value. It then scrambles both straps after capture. A design that kept sampling in a locked state would change target mid-run, and one that filtered dev like prod would lose the RISC-V TAP. The bench also drives TRST_N high on the external port to catch a design that lets an unselected target see a released reset. It drives random TDO values with the output enable low to catch TDO leaking through without its enable. A reference model also checks, cycle by cycle, the capture edge and the idle window before `lc_valid_i`, and that the DFT output is zero in locked states.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    localparam int LcW      = 5;
    localparam int StrapW   = 2;
    localparam int DftW     = 2;
    localparam int NumTaps  = 3;

    typedef enum logic [LcW-1:0] {
        LC_RAW         = 5'd0,
        LC_TEST_LOCKED = 5'd1,
        LC_TEST_UNL0   = 5'd2,
        LC_TEST_UNL7   = 5'd9,
        LC_DEV         = 5'd10,
        LC_PROD        = 5'd11,
        LC_PROD_END    = 5'd12,
        LC_RMA         = 5'd13,
        LC_SCRAP       = 5'd14
    } lc_state_e;

    typedef enum logic [StrapW-1:0] {
        TAP_NONE = 2'b00,
        TAP_LC   = 2'b01,
        TAP_RV   = 2'b10,
        TAP_DFT  = 2'b11
    } tap_sel_e;

    typedef struct packed {
        logic            captured;
        logic            live;
        tap_sel_e        sel;
        logic [DftW-1:0] dft;
    } mux_state_t;

    localparam mux_state_t STATE_RESET = '{
        captured: 1'b0,
        live:     1'b0,
        sel:      TAP_NONE,
        dft:      '0
    };

endpackage

// File: rtl/jsm_policy.sv
module jsm_policy
    import jsm_pkg::*;
(
    input  logic [LcW-1:0]    lc_state_i,
    input  logic [StrapW-1:0] strap_i,
    output logic              live_o,
    output tap_sel_e          sel_o
);

    logic is_unlocked;
    logic is_dev;

    always_comb begin
        is_unlocked = (lc_state_i >= LC_TEST_UNL0) && (lc_state_i <= LC_TEST_UNL7);
        is_dev      = (lc_state_i == LC_DEV);
        live_o      = is_unlocked || (lc_state_i == LC_RMA);

        if (live_o) begin
            sel_o = tap_sel_e'(strap_i);
        end else if (is_dev) begin
            sel_o = (tap_sel_e'(strap_i) == TAP_DFT) ? TAP_NONE : tap_sel_e'(strap_i);
        end else begin
            sel_o = strap_i[0] ? TAP_LC : TAP_NONE;
        end
    end

endmodule

// File: rtl/jsm_fanout.sv
module jsm_fanout
    import jsm_pkg::*;
#(
    parameter int Taps = NumTaps
) (
    input  tap_sel_e        sel_i,
    input  logic            tck_i,
    input  logic            tms_i,
    input  logic            tdi_i,
    input  logic            trst_n_i,
    output logic [Taps-1:0] tck_o,
    output logic [Taps-1:0] tms_o,
    output logic [Taps-1:0] tdi_o,
    output logic [Taps-1:0] trst_n_o
);

    for (genvar i = 0; i < Taps; i++) begin : g_tgt
        logic hit;
        assign hit         = (StrapW'(sel_i) == StrapW'(i + 1));
        assign tck_o[i]    = hit & tck_i;
        assign tms_o[i]    = hit & tms_i;
        assign tdi_o[i]    = hit & tdi_i;
        assign trst_n_o[i] = hit & trst_n_i;
    end

endmodule

// File: rtl/jsm_tdo_mux.sv
module jsm_tdo_mux
    import jsm_pkg::*;
#(
    parameter int Taps = NumTaps
) (
    input  tap_sel_e        sel_i,
    input  logic [Taps-1:0] tdo_i,
    input  logic [Taps-1:0] tdo_oe_i,
    output logic            tdo_o
);

    always_comb begin
        tdo_o = 1'b0;
        for (int i = 0; i < Taps; i++) begin
            if (StrapW'(sel_i) == StrapW'(i + 1)) begin
                tdo_o = tdo_i[i] & tdo_oe_i[i];
            end
        end
    end

endmodule

// File: rtl/jtag_strap_mux.sv
module jtag_strap_mux
    import jsm_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [LcW-1:0]      lc_state_i,
    input  logic                lc_valid_i,
    input  logic [StrapW-1:0]   tap_strap_i,
    input  logic [DftW-1:0]     dft_strap_i,
    input  logic                jtag_tck_i,
    input  logic                jtag_tms_i,
    input  logic                jtag_tdi_i,
    input  logic                jtag_trst_n_i,
    output logic                jtag_tdo_o,
    output logic [NumTaps-1:0]  tap_tck_o,
    output logic [NumTaps-1:0]  tap_tms_o,
    output logic [NumTaps-1:0]  tap_tdi_o,
    output logic [NumTaps-1:0]  tap_trst_n_o,
    input  logic [NumTaps-1:0]  tap_tdo_i,
    input  logic [NumTaps-1:0]  tap_tdo_oe_i,
    output logic [DftW-1:0]     dft_strap_o
);

    mux_state_t st_d, st_q;
    logic       pol_live;
    tap_sel_e   pol_sel;

    jsm_policy u_policy (
        .lc_state_i (lc_state_i),
        .strap_i    (tap_strap_i),
        .live_o     (pol_live),
        .sel_o      (pol_sel)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.captured) begin
            if (lc_valid_i) begin
                st_d.captured = 1'b1;
                st_d.live     = pol_live;
                st_d.sel      = pol_sel;
                st_d.dft      = pol_live ? dft_strap_i : '0;
            end
        end else if (st_q.live) begin
            st_d.sel = tap_sel_e'(tap_strap_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= STATE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    jsm_fanout #(.Taps(NumTaps)) u_fanout (
        .sel_i    (st_q.sel),
        .tck_i    (jtag_tck_i),
        .tms_i    (jtag_tms_i),
        .tdi_i    (jtag_tdi_i),
        .trst_n_i (jtag_trst_n_i),
        .tck_o    (tap_tck_o),
        .tms_o    (tap_tms_o),
        .tdi_o    (tap_tdi_o),
        .trst_n_o (tap_trst_n_o)
    );

    jsm_tdo_mux #(.Taps(NumTaps)) u_tdo (
        .sel_i    (st_q.sel),
        .tdo_i    (tap_tdo_i),
        .tdo_oe_i (tap_tdo_oe_i),
        .tdo_o    (jtag_tdo_o)
    );

    assign dft_strap_o = st_q.dft;

endmodule

// File: rtl/jsm_checker.sv
module jsm_checker
    import jsm_pkg::*;
(
    input logic                clk_i,
    input logic                rst_ni,
    input logic                captured_i,
    input logic                live_i,
    input logic [StrapW-1:0]   sel_i,
    input logic [LcW-1:0]      lc_state_i,
    input logic                lc_valid_i,
    input logic [StrapW-1:0]   tap_strap_i,
    input logic [NumTaps-1:0]  tck_i,
    input logic [NumTaps-1:0]  trst_n_i,
    input logic                tdo_i,
    input logic [DftW-1:0]     dft_i
);

    a_r1_idle_before_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !captured_i |-> (sel_i == 2'b00 && tck_i == '0 && trst_n_i == '0 && !tdo_i && dft_i == '0));

    a_r2_capture_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!captured_i && lc_valid_i) |=> captured_i);

    a_r4_live_follows_strap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (captured_i && $past(captured_i) && live_i) |-> (sel_i == $past(tap_strap_i)));

    a_r5_dev_blocks_dft: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(captured_i) && $past(lc_state_i) == LC_DEV) |-> (sel_i != 2'b11));

    a_r6_prod_lc_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(captured_i) && $past(lc_state_i) == LC_PROD) |-> (sel_i == 2'b00 || sel_i == 2'b01));

    a_r7_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (captured_i && $past(captured_i) && !live_i) |-> $stable(sel_i));

    a_r8_dft_zero_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (captured_i && !live_i) |-> (dft_i == '0));

    a_r9_dft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (captured_i && $past(captured_i)) |-> $stable(dft_i));

    a_r10_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($onehot0(tck_i) && $onehot0(trst_n_i)));

    a_r11_tdo_quiet_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == 2'b00) |-> !tdo_i);

endmodule

bind jtag_strap_mux jsm_checker u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .captured_i  (st_q.captured),
    .live_i      (st_q.live),
    .sel_i       (st_q.sel),
    .lc_state_i  (lc_state_i),
    .lc_valid_i  (lc_valid_i),
    .tap_strap_i (tap_strap_i),
    .tck_i       (tap_tck_o),
    .trst_n_i    (tap_trst_n_o),
    .tdo_i       (jtag_tdo_o),
    .dft_i       (dft_strap_o)
);

// File: tb/sim_jtag_strap_mux.sv
`timescale 1ns/1ps
module sim_jtag_strap_mux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] lc_state = '0;
    logic       lc_valid = 1'b0;
    logic [1:0] tap_strap = '0;
    logic [1:0] dft_strap = '0;
    logic       tck = 1'b0, tms = 1'b0, tdi = 1'b0, trst_n = 1'b0;
    logic       tdo;
    logic [2:0] t_tck, t_tms, t_tdi, t_trst_n;
    logic [2:0] t_tdo = '0, t_oe = '0;
    logic [1:0] dft_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    jtag_strap_mux u0 (
        .clk_i(clk), .rst_ni(rst_n), .lc_state_i(lc_state), .lc_valid_i(lc_valid),
        .tap_strap_i(tap_strap), .dft_strap_i(dft_strap),
        .jtag_tck_i(tck), .jtag_tms_i(tms), .jtag_tdi_i(tdi), .jtag_trst_n_i(trst_n),
        .jtag_tdo_o(tdo), .tap_tck_o(t_tck), .tap_tms_o(t_tms), .tap_tdi_o(t_tdi),
        .tap_trst_n_o(t_trst_n), .tap_tdo_i(t_tdo), .tap_tdo_oe_i(t_oe),
        .dft_strap_o(dft_out)
    );

    // Behavioural reference: which target is active, and the held DFT value.
    int         m_cap, m_live, m_sel;
    logic [1:0] m_dft;

    function automatic int is_live(int st);
        return ((st >= 2 && st <= 9) || st == 13) ? 1 : 0;
    endfunction

    function automatic int allowed(int st, int strap);
        if (is_live(st) != 0) return strap;
        if (st == 10) return (strap == 3) ? 0 : strap;
        return strap % 2;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cap = 0; m_live = 0; m_sel = 0; m_dft = 2'b00;
        end else if (m_cap == 0) begin
            if (lc_valid) begin
                m_cap  = 1;
                m_live = is_live(int'(lc_state));
                m_sel  = allowed(int'(lc_state), int'(tap_strap));
                m_dft  = (m_live != 0) ? dft_strap : 2'b00;
            end
        end else if (m_live != 0) begin
            m_sel = int'(tap_strap);
        end
    end

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [2:0] e_tck, e_tms, e_tdi, e_trst;
        logic       e_tdo;
        for (int i = 0; i < 3; i++) begin
            e_tck[i]  = (m_sel == i + 1) ? tck : 1'b0;
            e_tms[i]  = (m_sel == i + 1) ? tms : 1'b0;
            e_tdi[i]  = (m_sel == i + 1) ? tdi : 1'b0;
            e_trst[i] = (m_sel == i + 1) ? trst_n : 1'b0;
        end
        e_tdo = (m_sel == 0) ? 1'b0 : (t_tdo[m_sel-1] & t_oe[m_sel-1]);
        check(tag, "R10 tck", {1'b0, t_tck}, {1'b0, e_tck});
        check(tag, "R10 tms", {1'b0, t_tms}, {1'b0, e_tms});
        check(tag, "R10 tdi", {1'b0, t_tdi}, {1'b0, e_tdi});
        check(tag, "R10 trst_n", {1'b0, t_trst_n}, {1'b0, e_trst});
        check(tag, "R11 tdo", {3'b0, tdo}, {3'b0, e_tdo});
        check(tag, "R8 R9 dft", {2'b0, dft_out}, {2'b0, m_dft});
    endtask

    task automatic cycle(string tag);
        @(negedge clk);
        tck = 1'($urandom); tms = 1'($urandom); tdi = 1'($urandom);
        trst_n = 1'($urandom % 4 != 0);
        t_tdo = 3'($urandom); t_oe = 3'($urandom);
        #2;
        compare(tag);
    endtask

    task automatic run(int st, int strap0, string tag);
        rst_n = 1'b0; lc_valid = 1'b0;
        lc_state = 5'(st); tap_strap = 2'(strap0); dft_strap = 2'($urandom);
        cycle("R1"); cycle("R1");
        rst_n = 1'b1;
        cycle("R1"); cycle("R1");
        lc_valid = 1'b1;
        cycle("R2 R3"); cycle("R2 R3");
        for (int k = 0; k < 12; k++) begin
            tap_strap = 2'($urandom);
            dft_strap = 2'($urandom);
            if (k == 6) lc_state = 5'($urandom);
            if (k == 8) lc_valid = 1'b0;
            cycle(tag);
        end
    endtask

    initial begin
        for (int st = 0; st < 17; st++) begin
            int code = (st == 16) ? 31 : st;
            string tag;
            if (is_live(code) != 0) tag = "R4";
            else if (code == 10) tag = "R5";
            else if (code == 11) tag = "R6 R7";
            else tag = "R6 R7 other";
            for (int s = 0; s < 4; s++) run(code, s, tag);
        end
        // R4: deterministic walk through every target without reset
        run(13, 0, "R4");
        for (int s = 0; s < 4; s++) begin
            tap_strap = 2'(s);
            cycle("R4 walk"); cycle("R4 walk");
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule